// File: doc/BRIEF.md
# Bus-Multiplexed Up/Down Binary Counter

This block is a synchronous binary counter. Its parallel load data and its count value travel over one shared, bidirectional bus. A two-bit mode select picks one of four operations: load from the bus, count up, count down, or hold. An active-low count enable gates both count modes. An active-low output enable decides whether the counter drives the shared bus.

The shared bus is split into three signals: an input side, an output side and a drive flag. The flag is meant to control a tri-state buffer at the chip level. To load, the system releases the bus by raising the output enable, places the data on the bus and selects load mode.

An active-low terminal-count output is formed combinationally from the count value, the mode select and the count enable. It follows the counting direction. Feeding it into the count enable of the next counter builds a wider counter in which every stage moves on the same clock edge.

Top module: `bus_updown_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes zero.
- R2: With `mode_sel` = 2'b00 (load), the count takes the value of `bus_in` at the rising edge, whatever the value of `cnt_en_n`.
- R3: With `mode_sel` = 2'b10 (up) and `cnt_en_n` low, the count rises by one at each rising edge. All ones wraps to zero.
- R4: With `mode_sel` = 2'b01 (down) and `cnt_en_n` low, the count falls by one at each rising edge. Zero wraps to all ones.
- R5: With `mode_sel` = 2'b11, or with `cnt_en_n` high in either count mode, the count does not change.
- R6: `term_n` is low only in two cases: up mode with `cnt_en_n` low and the count at all ones, or down mode with `cnt_en_n` low and the count at zero. It is high in every other case, and it follows the mode and enable inputs without waiting for a clock edge.
- R7: `bus_drive` equals the inverse of `out_en_n`, and `bus_out` always carries the current count.
- R8: Load mode is legal only while `out_en_n` is high. A load while the counter drives the bus is flagged as misuse, and `bus_in` is still loaded.
- R9: In a chain where one stage's `term_n` drives the next stage's `cnt_en_n` and both share the mode select, the upper stage steps exactly on the edge where the lower stage wraps, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear |
| mode_sel | input | 2 | 00 load, 01 down, 10 up, 11 hold |
| cnt_en_n | input | 1 | Active-low count enable (cascade input) |
| out_en_n | input | 1 | Active-low enable for driving the bus |
| bus_in | input | WIDTH | Data read from the shared bus |
| bus_out | output | WIDTH | Count value for the shared bus |
| bus_drive | output | 1 | High when the counter must drive the bus |
| term_n | output | 1 | Active-low terminal count (cascade output) |

## Verification
The hardest case to reach is the upper stage of a cascade stepping. It happens only on the single edge where the lower stage sits at its end value with counting enabled, and it must happen in the direction that matches the mode.

The stimulus loads values next to the wrap points, such as one below all ones or one above zero. It then counts across the wrap in both directions while a scoreboard tracks both stages. Long random runs then mix the modes, the enables and loads of values close to the wrap points.

// File: rtl/bus_updown_counter.sv
module bus_updown_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             cnt_en_n,
  input  logic             out_en_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_drive,
  output logic             term_n
);

  localparam logic [1:0] M_LOAD = 2'b00;
  localparam logic [1:0] M_DOWN = 2'b01;
  localparam logic [1:0] M_UP   = 2'b10;
  localparam logic [1:0] M_HOLD = 2'b11;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt;
  logic             at_top, at_bot, going_up, going_dn;

  assign at_top   = &cnt;
  assign at_bot   = ~|cnt;
  assign going_up = (mode_sel == M_UP)   && !cnt_en_n;
  assign going_dn = (mode_sel == M_DOWN) && !cnt_en_n;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (mode_sel == M_LOAD) cnt <= bus_in;
    else if (going_up)       cnt <= cnt + ONE;
    else if (going_dn)       cnt <= cnt - ONE;
  end

  assign term_n    = ~((going_up && at_top) || (going_dn && at_bot));
  assign bus_out   = cnt;
  assign bus_drive = ~out_en_n;

  p_clear_r1: assert property (@(posedge clk)
    !rst_n |=> bus_out == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == M_LOAD |=> bus_out == $past(bus_in));

  p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_UP && !cnt_en_n) |=> bus_out == WIDTH'($past(bus_out) + ONE));

  p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_DOWN && !cnt_en_n) |=> bus_out == WIDTH'($past(bus_out) - ONE));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_HOLD || (mode_sel != M_LOAD && cnt_en_n)) |=> $stable(bus_out));

  p_tc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_n || mode_sel == M_HOLD || mode_sel == M_LOAD) |-> term_n);

  p_load_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == M_LOAD |-> out_en_n);

endmodule

// File: tb/bus_updown_counter_bench.sv
module bus_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       cen, oen;
  logic [7:0] din;
  logic [7:0] out0, out1;
  logic       drv0, drv1, tc0, tc1;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  lo_m, hi_m;
  logic [15:0] expq[$];
  string       tagq[$];

  always #5 clk = ~clk;

  bus_updown_counter #(.WIDTH(8)) u_bus_updown_counter (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .cnt_en_n(cen), .out_en_n(oen),
    .bus_in(din), .bus_out(out0), .bus_drive(drv0), .term_n(tc0));

  bus_updown_counter #(.WIDTH(8)) u_hi (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .cnt_en_n(tc0), .out_en_n(oen),
    .bus_in(din), .bus_out(out1), .bus_drive(drv1), .term_n(tc1));

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic en_n, input logic oe_n, input logic [7:0] d);
    logic t0;
    logic [7:0] nlo, nhi;
    string tag;
    @(negedge clk);
    mode = m; cen = en_n; oen = oe_n; din = d;
    #1;
    t0 = !(!en_n && ((m == 2'b10 && lo_m == 8'hFF) || (m == 2'b01 && lo_m == 8'h00)));
    check(tc0 === t0, "R6", {15'd0, tc0}, {15'd0, t0});
    check(drv0 === !oe_n, "R7", {15'd0, drv0}, {15'd0, !oe_n});
    nlo = lo_m; nhi = hi_m;
    case (m)
      2'b00: begin nlo = d; nhi = d; tag = "R2"; end
      2'b10: begin
        tag = en_n ? "R5" : "R3";
        if (!en_n) nlo = lo_m + 8'd1;
        if (!t0) begin nhi = hi_m + 8'd1; tag = "R9"; end
      end
      2'b01: begin
        tag = en_n ? "R5" : "R4";
        if (!en_n) nlo = lo_m - 8'd1;
        if (!t0) begin nhi = hi_m - 8'd1; tag = "R9"; end
      end
      default: tag = "R5";
    endcase
    lo_m = nlo; hi_m = nhi;
    expq.push_back({nhi, nlo});
    tagq.push_back(tag);
  endtask

  initial begin : monitor
    logic [15:0] e;
    string t;
    forever begin
      @(posedge clk); #2;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        t = tagq.pop_front();
        check({out1, out0} === e, t, {out1, out0}, e);
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; mode = 2'b11; cen = 1'b1; oen = 1'b1; din = 8'h5A;
    lo_m = 8'h00; hi_m = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({out1, out0} === 16'h0, "R1", {out1, out0}, 16'h0);
    check(tc0 === 1'b1, "R1", {15'd0, tc0}, 16'd1);
    rst_n = 1'b1;

    drive(2'b00, 1'b1, 1'b1, 8'hFD);
    drive(2'b10, 1'b0, 1'b0, 8'h00);
    drive(2'b10, 1'b0, 1'b0, 8'h00);
    drive(2'b11, 1'b0, 1'b0, 8'h00);
    drive(2'b10, 1'b1, 1'b0, 8'h00);
    drive(2'b10, 1'b0, 1'b0, 8'h00);
    drive(2'b10, 1'b0, 1'b0, 8'h00);
    drive(2'b00, 1'b0, 1'b1, 8'h02);
    drive(2'b01, 1'b0, 1'b0, 8'h00);
    drive(2'b01, 1'b0, 1'b0, 8'h00);
    drive(2'b01, 1'b1, 1'b1, 8'h00);
    drive(2'b11, 1'b1, 1'b0, 8'h00);
    drive(2'b01, 1'b0, 1'b0, 8'h00);
    drive(2'b01, 1'b0, 1'b0, 8'h00);

    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      logic [7:0] d;
      m = 2'($urandom_range(0, 3));
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (($urandom_range(0, 1) == 1) ? 8'hFE : 8'h01);
      drive(m, 1'($urandom_range(0, 3) == 0), (m == 2'b00) ? 1'b1 : 1'($urandom), d);
    end

    @(negedge clk); mode = 2'b11; cen = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule